// File: doc/BRIEF.md
# Video compare-and-set-predicate unit

This block compares two narrow operands drawn from packed register words and turns the result into predicate bits. Each operand is taken either as one byte lane or as one halfword of a register word, sign-extended or zero-extended on its own signedness flag. The second operand may instead come from a 16-bit immediate. A 4-bit condition code picks the relation tested between the two operands.

The comparison outcome is merged with a source predicate through a selectable AND, OR or XOR. The merged value goes to a main destination predicate. The inverted outcome, merged with the same source predicate through the same operator, goes to an inverse destination predicate. The block holds its own small predicate file: seven storage bits and one constant index that always reads true.

Operand fetch and instruction decode live elsewhere. This unit receives already-split fields along with a one-cycle `issue` strobe.

Top module: `vcmp_pred_unit`

## Requirements
- R1: After reset, predicate bits 0 to 6 (`pred_bits`) are all 0.
- R2: In narrow mode (`*_wide`=0), `*_pick` n selects byte lane n (bits 8n+7..8n). In wide mode, pick 0 selects bits 15..0 and pick 1 selects bits 31..16. A set signed flag sign-extends the field, otherwise it is zero-extended. With `b_from_reg`=0, operand B is `imm_b`, sign-extended when `b_signed`=1, and `b_wide`/`b_pick` are ignored.
- R3: The comparison is signed when either operand is signed and unsigned otherwise. The condition codes are 0 never, 1 A<B, 2 A==B, 3 A<=B, 4 A>B, 5 A!=B, 6 A>=B, 7 always.
- R4: The join codes are 0 AND, 1 OR and 2 XOR. They merge a term with the source predicate at `src_idx`, where index 7 reads as true.
- R5: The main destination receives (compare result) join (source). The inverse destination receives (NOT compare result) join (source).
- R6: When `dst_inv_idx` is 7, the inverse write is suppressed and the main write still occurs.
- R7: An illegal encoding leaves every predicate unchanged. The illegal encodings are join code 3, a condition code of 8 to 15, wide pick 2 or 3 on a register-sourced operand, and `dst_main_idx`=7.
- R8: Writes take effect on the rising edge that samples `issue`=1. A source read in the same cycle sees the value from before that edge, so back-to-back issues chain.
- R9: When both destinations name the same index, the main value is stored.
- R10: While `issue` is 0, no predicate changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | The operation fields are valid this cycle |
| opa_word | input | 32 | Register word holding operand A |
| opb_word | input | 32 | Register word holding operand B |
| imm_b | input | 16 | Immediate used for operand B when not register-sourced |
| a_wide | input | 1 | Operand A halfword mode (1) or byte mode (0) |
| a_signed | input | 1 | Operand A is signed |
| a_pick | input | 2 | Operand A byte lane or halfword select |
| b_wide | input | 1 | Operand B halfword mode (1) or byte mode (0) |
| b_signed | input | 1 | Operand B is signed |
| b_pick | input | 2 | Operand B byte lane or halfword select |
| b_from_reg | input | 1 | Operand B comes from `opb_word` (1) or `imm_b` (0) |
| cmp_code | input | 4 | Condition code |
| join_code | input | 2 | Join operator code |
| src_idx | input | 3 | Source predicate index |
| dst_main_idx | input | 3 | Main destination predicate index |
| dst_inv_idx | input | 3 | Inverse destination predicate index |
| pred_bits | output | 7 | Current contents of predicates 0 to 6 |

## Verification
The bench builds the unit with its default parameters: 32-bit register words, a 16-bit immediate and a 3-bit predicate index. These defaults make all four byte lanes, both halfwords and the constant index 7 reachable, so every selector and every illegal-index case can be driven. A vector table covers each condition code under mixed signedness, where a signed and an unsigned view of the same bits give opposite answers. Directed sequences then cover the join operators, suppression, illegal encodings, same-index collisions and chained back-to-back issues.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    localparam int PICK_W = 2;
    localparam int CMP_W  = 4;
    localparam int JOIN_W = 2;

    typedef enum logic [CMP_W-1:0] {
        CMP_NEVER  = 4'd0,
        CMP_LT     = 4'd1,
        CMP_EQ     = 4'd2,
        CMP_LE     = 4'd3,
        CMP_GT     = 4'd4,
        CMP_NE     = 4'd5,
        CMP_GE     = 4'd6,
        CMP_ALWAYS = 4'd7
    } cmp_code_e;

    typedef enum logic [JOIN_W-1:0] {
        JOIN_AND = 2'd0,
        JOIN_OR  = 2'd1,
        JOIN_XOR = 2'd2,
        JOIN_BAD = 2'd3
    } join_code_e;

    typedef enum logic [PICK_W-1:0] {
        HALF_LO   = 2'd0,
        HALF_HI   = 2'd1,
        HALF_FULL = 2'd2,
        HALF_RSVD = 2'd3
    } half_sel_e;

    function automatic logic join_apply(input join_code_e op, input logic term, input logic src);
        unique case (op)
            JOIN_AND: join_apply = term & src;
            JOIN_OR:  join_apply = term | src;
            JOIN_XOR: join_apply = term ^ src;
            default:  join_apply = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/vcmp_operand.sv
module vcmp_operand
    import vcmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int EXT_W  = 18
) (
    input  logic [DATA_W-1:0]       word,
    input  logic [IMM_W-1:0]        imm,
    input  logic                    from_reg,
    input  logic                    wide,
    input  logic                    sgn,
    input  logic [PICK_W-1:0]       pick,
    output logic signed [EXT_W-1:0] value,
    output logic                    bad
);
    localparam int NUM_LANES = DATA_W / 8;
    localparam int HALF_W    = DATA_W / 2;

    logic [7:0]        lanes [NUM_LANES];
    logic [7:0]        lane;
    logic [HALF_W-1:0] half_lo;
    logic [HALF_W-1:0] half_hi;

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            assign lanes[g] = word[g*8 +: 8];
        end
    endgenerate

    assign lane    = lanes[pick];
    assign half_lo = word[HALF_W-1:0];
    assign half_hi = word[DATA_W-1:HALF_W];

    always_comb begin
        bad   = 1'b0;
        value = '0;
        if (!from_reg) begin
            value = {{(EXT_W-IMM_W){sgn & imm[IMM_W-1]}}, imm};
        end else if (!wide) begin
            value = {{(EXT_W-8){sgn & lane[7]}}, lane};
        end else begin
            unique case (half_sel_e'(pick))
                HALF_LO: value = {{(EXT_W-HALF_W){sgn & half_lo[HALF_W-1]}}, half_lo};
                HALF_HI: value = {{(EXT_W-HALF_W){sgn & half_hi[HALF_W-1]}}, half_hi};
                default: bad = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/vcmp_compare.sv
module vcmp_compare
    import vcmp_pkg::*;
#(
    parameter int EXT_W = 18
) (
    input  logic signed [EXT_W-1:0] lhs,
    input  logic signed [EXT_W-1:0] rhs,
    input  logic [CMP_W-1:0]        code,
    output logic                    hit,
    output logic                    bad
);
    logic lt;
    logic eq;

    assign lt = lhs < rhs;
    assign eq = lhs == rhs;

    always_comb begin
        bad = 1'b0;
        hit = 1'b0;
        unique case (cmp_code_e'(code))
            CMP_NEVER:  hit = 1'b0;
            CMP_LT:     hit = lt;
            CMP_EQ:     hit = eq;
            CMP_LE:     hit = lt | eq;
            CMP_GT:     hit = !(lt | eq);
            CMP_NE:     hit = !eq;
            CMP_GE:     hit = !lt;
            CMP_ALWAYS: hit = 1'b1;
            default:    bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/vcmp_pred_file.sv
module vcmp_pred_file #(
    parameter int PIDX_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIDX_W-1:0]     rd_idx,
    output logic                  rd_val,
    input  logic                  w0_en,
    input  logic [PIDX_W-1:0]     w0_idx,
    input  logic                  w0_val,
    input  logic                  w1_en,
    input  logic [PIDX_W-1:0]     w1_idx,
    input  logic                  w1_val,
    output logic [(1<<PIDX_W)-2:0] state
);
    localparam int NUM_PRED = 1 << PIDX_W;
    localparam int NUM_STORE = NUM_PRED - 1;
    localparam logic [PIDX_W-1:0] CONST_IDX = PIDX_W'(NUM_PRED - 1);

    logic [NUM_STORE-1:0] pred_q;
    logic [NUM_PRED-1:0]  view;

    assign view   = {1'b1, pred_q};
    assign rd_val = view[rd_idx];
    assign state  = pred_q;

    generate
        for (genvar i = 0; i < NUM_STORE; i++) begin : g_bit
            logic hit0;
            logic hit1;
            assign hit0 = w0_en && (w0_idx == PIDX_W'(i));
            assign hit1 = w1_en && (w1_idx == PIDX_W'(i));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pred_q[i] <= 1'b0;
                end else if (hit0) begin
                    pred_q[i] <= w0_val;
                end else if (hit1) begin
                    pred_q[i] <= w1_val;
                end
            end
        end
    endgenerate

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> pred_q == '0); // R1
    AST_SEC_NOT_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        w1_en |-> w1_idx != CONST_IDX); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !w0_en && !w1_en |=> $stable(pred_q)); // R10

endmodule

// File: rtl/vcmp_pred_unit.sv
module vcmp_pred_unit
    import vcmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int PIDX_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      issue,
    input  logic [DATA_W-1:0]         opa_word,
    input  logic [DATA_W-1:0]         opb_word,
    input  logic [IMM_W-1:0]          imm_b,
    input  logic                      a_wide,
    input  logic                      a_signed,
    input  logic [1:0]                a_pick,
    input  logic                      b_wide,
    input  logic                      b_signed,
    input  logic [1:0]                b_pick,
    input  logic                      b_from_reg,
    input  logic [3:0]                cmp_code,
    input  logic [1:0]                join_code,
    input  logic [PIDX_W-1:0]         src_idx,
    input  logic [PIDX_W-1:0]         dst_main_idx,
    input  logic [PIDX_W-1:0]         dst_inv_idx,
    output logic [(1<<PIDX_W)-2:0]    pred_bits
);
    localparam int HALF_W   = DATA_W / 2;
    localparam int RAW_W    = (HALF_W > IMM_W) ? HALF_W : IMM_W;
    localparam int EXT_W    = RAW_W + 2;
    localparam int NUM_PRED = 1 << PIDX_W;
    localparam logic [PIDX_W-1:0] CONST_IDX = PIDX_W'(NUM_PRED - 1);

    logic signed [EXT_W-1:0] val_a;
    logic signed [EXT_W-1:0] val_b;
    logic                    bad_a;
    logic                    bad_b;
    logic                    cmp_hit;
    logic                    cmp_bad;
    logic                    src_val;
    logic                    legal;
    logic                    main_val;
    logic                    inv_val;
    logic                    main_en;
    logic                    inv_en;
    join_code_e              join_op;

    vcmp_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W), .EXT_W(EXT_W)) u_opa (
        .word     (opa_word),
        .imm      ('0),
        .from_reg (1'b1),
        .wide     (a_wide),
        .sgn      (a_signed),
        .pick     (a_pick),
        .value    (val_a),
        .bad      (bad_a)
    );

    vcmp_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W), .EXT_W(EXT_W)) u_opb (
        .word     (opb_word),
        .imm      (imm_b),
        .from_reg (b_from_reg),
        .wide     (b_wide),
        .sgn      (b_signed),
        .pick     (b_pick),
        .value    (val_b),
        .bad      (bad_b)
    );

    vcmp_compare #(.EXT_W(EXT_W)) u_cmp (
        .lhs  (val_a),
        .rhs  (val_b),
        .code (cmp_code),
        .hit  (cmp_hit),
        .bad  (cmp_bad)
    );

    assign join_op  = join_code_e'(join_code);
    assign legal    = !bad_a && !bad_b && !cmp_bad && (join_op != JOIN_BAD)
                      && (dst_main_idx != CONST_IDX);
    assign main_val = join_apply(join_op, cmp_hit, src_val);
    assign inv_val  = join_apply(join_op, !cmp_hit, src_val);
    assign main_en  = issue && legal;
    assign inv_en   = issue && legal && (dst_inv_idx != CONST_IDX);

    vcmp_pred_file #(.PIDX_W(PIDX_W)) u_pfile (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (src_idx),
        .rd_val (src_val),
        .w0_en  (main_en),
        .w0_idx (dst_main_idx),
        .w0_val (main_val),
        .w1_en  (inv_en),
        .w1_idx (dst_inv_idx),
        .w1_val (inv_val),
        .state  (pred_bits)
    );

    logic ops_ok;
    assign ops_ok = !(a_wide && a_pick[1]) && !(b_from_reg && b_wide && b_pick[1]);

    AST_BAD_JOIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        issue && join_code == 2'd3 |=> $stable(pred_bits)); // R7
    AST_MAIN_CONST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        issue && dst_main_idx == CONST_IDX |=> $stable(pred_bits)); // R7
    AST_ALWAYS_OR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        issue && ops_ok && cmp_code == 4'd7 && join_code == 2'd1 && dst_main_idx != CONST_IDX
        |=> pred_bits[$past(dst_main_idx)]); // R5
    AST_XOR_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        issue && ops_ok && cmp_code == 4'd7 && join_code == 2'd2 && src_idx == CONST_IDX
        && dst_main_idx != dst_inv_idx && dst_main_idx != CONST_IDX && dst_inv_idx != CONST_IDX
        |=> !pred_bits[$past(dst_main_idx)] && pred_bits[$past(dst_inv_idx)]); // R4

endmodule

// File: tb/tb_vcmp_pred_unit.sv
`timescale 1ns/1ps
module tb_vcmp_pred_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] opa_word = '0;
    logic [31:0] opb_word = '0;
    logic [15:0] imm_b = '0;
    logic        a_wide = 1'b0, a_signed = 1'b0, b_wide = 1'b0, b_signed = 1'b0, b_from_reg = 1'b1;
    logic [1:0]  a_pick = '0, b_pick = '0, join_code = '0;
    logic [3:0]  cmp_code = '0;
    logic [2:0]  src_idx = 3'd7, dst_main_idx = '0, dst_inv_idx = 3'd1;
    logic [6:0]  pred_bits;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vcmp_pred_unit dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opa_word(opa_word), .opb_word(opb_word),
        .imm_b(imm_b), .a_wide(a_wide), .a_signed(a_signed), .a_pick(a_pick),
        .b_wide(b_wide), .b_signed(b_signed), .b_pick(b_pick), .b_from_reg(b_from_reg),
        .cmp_code(cmp_code), .join_code(join_code), .src_idx(src_idx),
        .dst_main_idx(dst_main_idx), .dst_inv_idx(dst_inv_idx), .pred_bits(pred_bits)
    );

    // Fields: a[93:62] b[61:30] imm[29:14] aw[13] as[12] ap[11:10] bw[9] bs[8] bp[7:6] breg[5] cmp[4:1] exp[0]
    localparam int NV = 17;
    localparam logic [93:0] VEC [NV] = '{
        {32'h12,       32'h34,       16'h0,    1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0, 1'b1, 4'd1, 1'b1},
        {32'hFF00,     32'h01,       16'h0,    1'b0,1'b0,2'd1, 1'b0,1'b1,2'd0, 1'b1, 4'd4, 1'b1},
        {32'hFF00,     32'h01,       16'h0,    1'b0,1'b1,2'd1, 1'b0,1'b0,2'd0, 1'b1, 4'd1, 1'b1},
        {32'hFF00,     32'hFF,       16'h0,    1'b0,1'b0,2'd1, 1'b0,1'b1,2'd0, 1'b1, 4'd2, 1'b0},
        {32'h12345678, 32'h56780000, 16'h0,    1'b1,1'b0,2'd0, 1'b1,1'b0,2'd1, 1'b1, 4'd2, 1'b1},
        {32'h80000000, 32'h0,        16'h0001, 1'b1,1'b1,2'd1, 1'b0,1'b0,2'd0, 1'b0, 4'd1, 1'b1},
        {32'h80000000, 32'h0,        16'h0001, 1'b1,1'b0,2'd1, 1'b0,1'b0,2'd0, 1'b0, 4'd3, 1'b0},
        {32'hAB000000, 32'h0,        16'hFFFF, 1'b0,1'b0,2'd3, 1'b0,1'b1,2'd0, 1'b0, 4'd6, 1'b1},
        {32'h00330000, 32'h33000000, 16'h0,    1'b0,1'b0,2'd2, 1'b0,1'b0,2'd3, 1'b1, 4'd5, 1'b0},
        {32'h5,        32'h5,        16'h0,    1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0, 1'b1, 4'd0, 1'b0},
        {32'h5,        32'h5,        16'h0,    1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0, 1'b1, 4'd7, 1'b1},
        {32'h5,        32'h5,        16'h0,    1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0, 1'b1, 4'd3, 1'b1},
        {32'h5,        32'h5,        16'h0,    1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0, 1'b1, 4'd6, 1'b1},
        {32'h5,        32'h5,        16'h0,    1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0, 1'b1, 4'd4, 1'b0},
        {32'h80,       32'h7F,       16'h0,    1'b0,1'b1,2'd0, 1'b0,1'b0,2'd0, 1'b1, 4'd1, 1'b1},
        {32'h1,        32'h0,        16'hFFFF, 1'b1,1'b0,2'd0, 1'b0,1'b0,2'd0, 1'b0, 4'd1, 1'b1},
        {32'h1,        32'h0,        16'hFFFF, 1'b1,1'b0,2'd0, 1'b1,1'b0,2'd3, 1'b0, 4'd1, 1'b1}
    };

    task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: pred_bits got %b expected %b", req, got, exp);
        end
    endtask

    task automatic set_ctl(input logic [3:0] cc, input logic [1:0] jc, input logic [2:0] s,
                           input logic [2:0] dm, input logic [2:0] di);
        cmp_code = cc; join_code = jc; src_idx = s; dst_main_idx = dm; dst_inv_idx = di;
    endtask

    task automatic fire();
        @(negedge clk);
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
    endtask

    task automatic neutral_ops();
        opa_word = 32'h5; opb_word = 32'h5; imm_b = '0;
        a_wide = 0; a_signed = 0; a_pick = 0; b_wide = 0; b_signed = 0; b_pick = 0; b_from_reg = 1;
    endtask

    initial begin
        logic [6:0] snap;
        repeat (3) @(negedge clk);
        check("R1 reset clear", pred_bits, 7'b0);
        rst_n = 1'b1;

        // R2 R3: operand extraction and condition codes; main=0, inverse=1, AND with true
        for (int i = 0; i < NV; i++) begin
            opa_word = VEC[i][93:62]; opb_word = VEC[i][61:30]; imm_b = VEC[i][29:14];
            a_wide = VEC[i][13]; a_signed = VEC[i][12]; a_pick = VEC[i][11:10];
            b_wide = VEC[i][9]; b_signed = VEC[i][8]; b_pick = VEC[i][7:6]; b_from_reg = VEC[i][5];
            set_ctl(VEC[i][4:1], 2'd0, 3'd7, 3'd0, 3'd1);
            fire();
            check($sformatf("R2/R3 vector %0d", i), pred_bits, {5'b0, ~VEC[i][0], VEC[i][0]});
        end

        neutral_ops();
        snap = pred_bits;
        // R6: inverse to constant index suppressed, main still written
        set_ctl(4'd7, 2'd0, 3'd7, 3'd2, 3'd7); fire();
        snap[2] = 1'b1;
        check("R6 inverse to index 7", pred_bits, snap);
        // R4 R5: OR with source pred2=1, compare never
        set_ctl(4'd0, 2'd1, 3'd2, 3'd3, 3'd4); fire();
        snap[3] = 1'b1; snap[4] = 1'b1;
        check("R4 OR join", pred_bits, snap);
        // R4 R5: XOR with source true, compare always
        set_ctl(4'd7, 2'd2, 3'd2, 3'd5, 3'd6); fire();
        snap[5] = 1'b0; snap[6] = 1'b1;
        check("R5 XOR join", pred_bits, snap);
        // R4: AND with false source pred5
        set_ctl(4'd7, 2'd0, 3'd5, 3'd3, 3'd4); fire();
        snap[3] = 1'b0; snap[4] = 1'b0;
        check("R4 AND false source", pred_bits, snap);

        // R7: illegal encodings would set pred5=1, pred6=0
        set_ctl(4'd7, 2'd3, 3'd7, 3'd5, 3'd6); fire();
        check("R7 join code 3", pred_bits, snap);
        set_ctl(4'd9, 2'd0, 3'd7, 3'd5, 3'd6); fire();
        check("R7 cmp code 9", pred_bits, snap);
        set_ctl(4'd7, 2'd0, 3'd7, 3'd5, 3'd6);
        a_wide = 1; a_pick = 2; fire();
        check("R7 A wide pick 2", pred_bits, snap);
        a_wide = 0; a_pick = 0; b_wide = 1; b_pick = 3; fire();
        check("R7 B wide pick 3", pred_bits, snap);
        neutral_ops();
        set_ctl(4'd7, 2'd0, 3'd7, 3'd7, 3'd6); fire();
        check("R7 main index 7", pred_bits, snap);

        // R10: idle cycles with a writing operation on the fields
        set_ctl(4'd7, 2'd0, 3'd7, 3'd5, 3'd6);
        repeat (3) @(negedge clk);
        check("R10 issue low", pred_bits, snap);

        // R9: same index both destinations, main value (1) kept
        set_ctl(4'd7, 2'd0, 3'd7, 3'd5, 3'd5); fire();
        snap[5] = 1'b1;
        check("R9 same index", pred_bits, snap);

        // R8: back-to-back chained XOR on pred4
        set_ctl(4'd7, 2'd2, 3'd4, 3'd4, 3'd7);
        @(negedge clk);
        issue = 1'b1;
        #1 check("R8 no change before edge", pred_bits, snap);
        @(negedge clk);
        snap[4] = 1'b1;
        check("R8 first write", pred_bits, snap);
        @(negedge clk);
        issue = 1'b0;
        snap[4] = 1'b0;
        check("R8 chained read of new value", pred_bits, snap);

        // R1: reset again clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 second reset", pred_bits, 7'b0);
        rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule